// File: doc/BRIEF.md
# Serial Transport Stream Sync Locker

This block takes a transport stream arriving one bit per qualified clock, most significant bit first, and assembles it into bytes. Before it trusts the stream it hunts for the sync value 0x47 at every bit offset. Once a candidate is found, it measures the distance to the next sync byte, which may be 188 or 204 bytes. It declares lock only after five sync bytes have been seen, each at that same spacing.

While locked, the block checks a single byte per packet: the one where the next sync byte must sit. Every byte of the locked stream goes into a small show-ahead FIFO, tagged with a packet-start flag, and the downstream core drains it. If an expected sync byte does not arrive, the block pulses an interrupt, drops lock and resumes the bit-wise hunt.

Top module: `ts_sync_locker`

## Requirements
- R1: After reset, `locked` is 0, `pkt_len` is 0, `sync_lost` is 0 and `rd_valid` is 0.
- R2: A bit is taken only in a cycle where `ser_valid` is 1. Bits form bytes MSB first. When `ser_valid` is 0, the value on `ser_bit` has no effect.
- R3: While hunting, the block compares the last eight accepted bits with 0x47 after every accepted bit. A match fixes the byte alignment and makes that byte the first candidate sync byte.
- R4: After a candidate, the byte 188 positions on is tested first and the byte 204 positions on second. The first spacing that holds is kept, and every later sync byte must follow at that spacing. Lock is declared on the fifth sync byte in the chain. A failed test returns the block to the hunt, so fewer than five hits, or any other spacing, never gives lock.
- R5: `pkt_len` reads 188 or 204 (the spacing in use) while `locked` is 1, and reads 0 otherwise.
- R6: While locked, only the byte at the packet boundary is compared against 0x47. A 0x47 value anywhere in the payload has no effect on lock or on the packet-start flag.
- R7: FIFO entries are written only while locked. The first entry is the fifth sync byte itself. `rd_sop` is 1 exactly for entries that are sync bytes at a packet boundary. Bytes received before lock are never written.
- R8: If the boundary byte is not 0x47 while locked, `sync_lost` is 1 for exactly one cycle and `locked` falls in that same cycle. The bad byte is not written, and the hunt restarts with the next accepted bit.
- R9: The FIFO holds 16 entries. A byte arriving while it is full is discarded and the stored entries are kept. `rd_data`/`rd_sop` show the oldest entry whenever `rd_valid` is 1, and `rd_en` removes it at the clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one serial bit may be taken per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| ser_bit | input | 1 | Serial stream bit, MSB of each byte first |
| ser_valid | input | 1 | Qualifies `ser_bit` in this cycle |
| rd_en | input | 1 | Pops the FIFO head when `rd_valid` is 1 |
| rd_valid | output | 1 | FIFO holds at least one entry |
| rd_data | output | 8 | Byte at the FIFO head |
| rd_sop | output | 1 | FIFO head is a packet-start sync byte |
| locked | output | 1 | Stream is aligned and locked |
| pkt_len | output | 8 | Packet length in use while locked (188 or 204), else 0 |
| sync_lost | output | 1 | One-cycle interrupt pulse when a locked sync byte is missing |

## Verification
A wrong bit counter or a wrong alignment shows up at the first byte written after lock: `rd_data` differs from the model on the same cycle the entry becomes visible. A wrong spacing counter or a wrong hit counter moves the rise of `locked` by at least one packet, or stops it altogether. An error in the locked boundary check appears as a `sync_lost` pulse that is missing or falls in the wrong cycle, or as `rd_sop` set on the wrong entry. The reference model runs every clock, so any of these is caught within one cycle of the first port difference.

// File: rtl/ts_sync_locker.sv
module ts_sync_locker #(
  parameter logic [7:0] SYNC       = 8'h47,
  parameter int         LEN_A      = 188,
  parameter int         LEN_B      = 204,
  parameter int         LOCK_HITS  = 5,
  parameter int         FIFO_DEPTH = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          ser_bit,
  input  logic                          ser_valid,
  input  logic                          rd_en,
  output logic                          rd_valid,
  output logic [7:0]                    rd_data,
  output logic                          rd_sop,
  output logic                          locked,
  output logic [$clog2(LEN_B+1)-1:0]    pkt_len,
  output logic                          sync_lost
);
  localparam int CW = $clog2(LEN_B + 1);
  localparam int HW = $clog2(LOCK_HITS + 1);
  localparam int AW = (FIFO_DEPTH > 1) ? $clog2(FIFO_DEPTH) : 1;

  typedef enum logic [1:0] {HUNT, CHECK, LOCK} state_t;

  state_t        st;
  logic [7:0]    shreg;
  logic [2:0]    bcnt;
  logic [CW-1:0] idx;
  logic [CW-1:0] len;
  logic [HW-1:0] hits;

  wire [7:0]    nxt       = {shreg[6:0], ser_bit};
  wire          is_sync   = (nxt == SYNC);
  wire          byte_done = ser_valid && (bcnt == 3'd7);
  wire [CW-1:0] nidx      = idx + 1'b1;
  wire          at_a      = (len == '0) && (nidx == CW'(LEN_A));
  wire          at_b      = (len == '0) && (nidx == CW'(LEN_B));
  wire          at_len    = (len != '0) && (nidx == len);
  wire          boundary  = at_len || at_b || (at_a && is_sync);
  wire          accept    = byte_done && boundary && is_sync;
  wire          last_hit  = (hits == HW'(LOCK_HITS - 1));
  wire [CW-1:0] new_len   = at_a ? CW'(LEN_A) : (at_b ? CW'(LEN_B) : len);

  wire wr_req = (st == CHECK && accept && last_hit) ||
                (st == LOCK && byte_done && (!boundary || is_sync));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= HUNT;
      shreg     <= '0;
      bcnt      <= '0;
      idx       <= '0;
      len       <= '0;
      hits      <= '0;
      sync_lost <= 1'b0;
    end else begin
      sync_lost <= 1'b0;
      if (ser_valid) shreg <= nxt;
      case (st)
        HUNT: if (ser_valid && is_sync) begin
          st   <= CHECK;
          bcnt <= '0;
          idx  <= '0;
          len  <= '0;
          hits <= HW'(1);
        end
        CHECK: if (ser_valid) begin
          bcnt <= bcnt + 1'b1;
          if (byte_done) begin
            if (!boundary) idx <= nidx;
            else if (is_sync) begin
              idx  <= '0;
              len  <= new_len;
              hits <= hits + 1'b1;
              if (last_hit) st <= LOCK;
            end else begin
              st  <= HUNT;
              len <= '0;
            end
          end
        end
        LOCK: if (ser_valid) begin
          bcnt <= bcnt + 1'b1;
          if (byte_done) begin
            if (!boundary) idx <= nidx;
            else if (is_sync) idx <= '0;
            else begin
              st        <= HUNT;
              len       <= '0;
              sync_lost <= 1'b1;
            end
          end
        end
        default: st <= HUNT;
      endcase
    end
  end

  assign locked  = (st == LOCK);
  assign pkt_len = locked ? len : '0;

  logic [8:0]  mem [FIFO_DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic [AW:0]   cnt;

  wire do_wr = wr_req && (cnt != (AW+1)'(FIFO_DEPTH));
  wire do_rd = rd_en && (cnt != '0);

  always_ff @(posedge clk) begin
    if (do_wr) mem[wptr] <= {boundary, nxt};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wptr <= '0;
      rptr <= '0;
      cnt  <= '0;
    end else begin
      if (do_wr) wptr <= (wptr == AW'(FIFO_DEPTH - 1)) ? '0 : wptr + 1'b1;
      if (do_rd) rptr <= (rptr == AW'(FIFO_DEPTH - 1)) ? '0 : rptr + 1'b1;
      case ({do_wr, do_rd})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end

  assign rd_valid = (cnt != '0);
  assign {rd_sop, rd_data} = mem[rptr];
endmodule

// File: rtl/ts_sync_locker_chk.sv
module ts_sync_locker_chk #(
  parameter logic [7:0] SYNC  = 8'h47,
  parameter int         LEN_A = 188,
  parameter int         LEN_B = 204,
  parameter int         CW    = 8,
  parameter int         AW    = 4,
  parameter int         DEPTH = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          rd_en,
  input logic          rd_valid,
  input logic [7:0]    rd_data,
  input logic          rd_sop,
  input logic          locked,
  input logic [CW-1:0] pkt_len,
  input logic          sync_lost,
  input logic [AW:0]   fill
);
  p_len_locked_r5: assert property (@(posedge clk) disable iff (!rst_n)
    locked |-> (pkt_len == CW'(LEN_A) || pkt_len == CW'(LEN_B)));

  p_len_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !locked |-> (pkt_len == '0));

  p_lost_drops_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |-> (!locked && $past(locked)));

  p_lost_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    sync_lost |=> !sync_lost);

  p_sop_is_sync_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_sop) |-> (rd_data == SYNC));

  p_head_held_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_en) |=> (rd_valid && $stable(rd_data) && $stable(rd_sop)));

  p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
    fill <= (AW+1)'(DEPTH));
endmodule

bind ts_sync_locker ts_sync_locker_chk #(
  .SYNC(SYNC), .LEN_A(LEN_A), .LEN_B(LEN_B),
  .CW(CW), .AW(AW), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_en(rd_en), .rd_valid(rd_valid),
  .rd_data(rd_data), .rd_sop(rd_sop), .locked(locked),
  .pkt_len(pkt_len), .sync_lost(sync_lost), .fill(cnt)
);

// File: tb/ts_sync_locker_tb.sv
module ts_sync_locker_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       ser_bit = 1'b0;
  logic       ser_valid = 1'b0;
  logic       rd_en = 1'b1;
  logic       rd_valid;
  logic [7:0] rd_data;
  logic       rd_sop;
  logic       locked;
  logic [7:0] pkt_len;
  logic       sync_lost;

  always #2 clk = ~clk;

  ts_sync_locker u_dut (
    .clk(clk), .rst_n(rst_n), .ser_bit(ser_bit), .ser_valid(ser_valid),
    .rd_en(rd_en), .rd_valid(rd_valid), .rd_data(rd_data), .rd_sop(rd_sop),
    .locked(locked), .pkt_len(pkt_len), .sync_lost(sync_lost)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  bit gap_on = 0;
  int pcount = 0;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s: actual=%0d expected=%0d at cycle %0d", tag, act, exp, cyc);
    end
  endtask

  // reference model
  int m_state = 0;
  int m_sh = 0, m_bc = 0, m_idx = 0, m_len = 0, m_hits = 0;
  bit m_lost = 0;
  logic [8:0] q[$];

  always @(posedge clk) begin
    int sz;
    bit push, psop, good, fail;
    if (!rst_n) begin
      m_state = 0; m_sh = 0; m_bc = 0; m_idx = 0; m_len = 0; m_hits = 0; m_lost = 0;
      q.delete();
    end else begin
      sz = q.size(); push = 0; psop = 0; m_lost = 0;
      if (ser_valid) begin
        m_sh = ((m_sh << 1) | int'(ser_bit)) & 255;
        if (m_state == 0) begin
          if (m_sh == 8'h47) begin
            m_state = 1; m_bc = 0; m_idx = 0; m_len = 0; m_hits = 1;
          end
        end else begin
          m_bc++;
          if (m_bc == 8) begin
            m_bc = 0; m_idx++;
            if (m_state == 1) begin
              good = 0; fail = 0;
              if (m_len == 0) begin
                if (m_idx == 188 && m_sh == 8'h47) begin good = 1; m_len = 188; end
                else if (m_idx == 204) begin
                  if (m_sh == 8'h47) begin good = 1; m_len = 204; end else fail = 1;
                end
              end else if (m_idx == m_len) begin
                if (m_sh == 8'h47) good = 1; else fail = 1;
              end
              if (good) begin
                m_idx = 0; m_hits++;
                if (m_hits == 5) begin m_state = 2; push = 1; psop = 1; end
              end
              if (fail) begin m_state = 0; m_len = 0; end
            end else begin
              if (m_idx == m_len) begin
                if (m_sh == 8'h47) begin m_idx = 0; push = 1; psop = 1; end
                else begin m_state = 0; m_lost = 1; m_len = 0; end
              end else push = 1;
            end
          end
        end
      end
      if (rd_en && sz > 0) void'(q.pop_front());
      if (push && sz < 16) q.push_back({psop, m_sh[7:0]});
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R4 locked", int'(locked), int'(m_state == 2));
      chk("R5 pkt_len", int'(pkt_len), (m_state == 2) ? m_len : 0);
      chk("R8 sync_lost", int'(sync_lost), int'(m_lost));
      chk("R9 rd_valid", int'(rd_valid), int'(q.size() > 0));
      if (q.size() > 0 && rd_valid) begin
        chk("R7 rd_data", int'(rd_data), int'(q[0][7:0]));
        chk("R7 rd_sop", int'(rd_sop), int'(q[0][8]));
      end
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL watchdog: actual=%0d expected<=150000 cycles", cyc);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  function automatic logic [7:0] pay(input int n, input bit allow47);
    if (allow47 && (n % 37) == 5) return 8'h47;
    case (n % 8)
      0: return 8'hB5; 1: return 8'hAD; 2: return 8'hDB; 3: return 8'hED;
      4: return 8'hF7; 5: return 8'hBB; 6: return 8'hD5; default: return 8'hFF;
    endcase
  endfunction

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) begin
      ser_bit = b[i]; ser_valid = 1'b1;
      @(negedge clk);
      if (gap_on && i == 4) begin
        ser_bit = ~b[i]; ser_valid = 1'b0;
        @(negedge clk);
      end
    end
    ser_valid = 1'b0;
  endtask

  task automatic send_payload(input int n, input bit allow47);
    for (int k = 0; k < n; k++) begin
      send_byte(pay(pcount, allow47));
      pcount++;
    end
  endtask

  task automatic send_pkt(input int len, input bit allow47);
    send_byte(8'h47);
    send_payload(len - 1, allow47);
  endtask

  task automatic send_bitv(input logic b);
    ser_bit = b; ser_valid = 1'b1;
    @(negedge clk);
    ser_valid = 1'b0;
  endtask

  initial begin
    int pops;
    int sops;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 locked after reset", int'(locked), 0);
    chk("R1 pkt_len after reset", int'(pkt_len), 0);
    chk("R1 sync_lost after reset", int'(sync_lost), 0);
    chk("R1 rd_valid after reset", int'(rd_valid), 0);

    // R3: misaligned start, lock at 188
    send_bitv(1'b1); send_bitv(1'b1); send_bitv(1'b0);
    for (int p = 0; p < 4; p++) send_pkt(188, 1'b0);
    chk("R4 no lock after four syncs", int'(locked), 0);
    chk("R7 nothing written before lock", int'(rd_valid), 0);
    send_byte(8'h47);
    chk("R4 lock on fifth sync (188)", int'(locked), 1);
    chk("R5 length 188", int'(pkt_len), 188);
    chk("R7 fifth sync visible as first entry", int'(rd_valid), 1);
    chk("R7 first entry is sync", int'(rd_data), 8'h47);
    chk("R7 first entry flagged", int'(rd_sop), 1);

    // R6: payload 0x47 ignored
    send_payload(187, 1'b1);
    send_pkt(188, 1'b1);
    send_pkt(188, 1'b1);
    chk("R6 lock kept with 0x47 payload", int'(locked), 1);

    // R8: missing sync
    send_byte(8'hB5);
    chk("R8 lock dropped", int'(locked), 0);
    chk("R8 interrupt pulse", int'(sync_lost), 1);
    chk("R5 length cleared", int'(pkt_len), 0);
    @(negedge clk);
    chk("R8 pulse one cycle", int'(sync_lost), 0);

    // R2 and R4: 204 spacing with idle gaps
    gap_on = 1;
    for (int p = 0; p < 4; p++) send_pkt(204, 1'b0);
    send_byte(8'h47);
    chk("R2 R4 lock at 204 with gaps", int'(locked), 1);
    chk("R5 length 204", int'(pkt_len), 204);
    send_payload(203, 1'b1);
    send_byte(8'hB5);
    chk("R8 lock dropped at 204", int'(locked), 0);
    gap_on = 0;

    // R4: wrong spacing never locks
    for (int p = 0; p < 6; p++) send_pkt(200, 1'b0);
    chk("R4 spacing 200 no lock", int'(locked), 0);
    chk("R4 spacing 200 length zero", int'(pkt_len), 0);

    // R9: full FIFO drops
    rd_en = 1'b0;
    for (int p = 0; p < 4; p++) send_pkt(188, 1'b0);
    send_pkt(41, 1'b0);
    chk("R9 head held", int'(rd_data), 8'h47);
    chk("R9 head flag held", int'(rd_sop), 1);
    rd_en = 1'b1;
    pops = 0; sops = 0;
    for (int i = 0; i < 40; i++) begin
      if (rd_valid) begin pops++; if (rd_sop) sops++; end
      @(negedge clk);
    end
    chk("R9 exactly depth entries kept", pops, 16);
    chk("R7 one packet start among kept", sops, 1);
    chk("R9 empty after drain", int'(rd_valid), 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule